// File: doc/BRIEF.md
# Three-Segment Interpolating Gamma Curve

This block applies a programmable transfer curve to the red, green and blue components of one pixel per clock. Each component enters as an unsigned value with 3 integer bits and 18 fraction bits, so 1.0 is 2^18. Each channel has its own piecewise-linear curve built from three point sets. A superfine set of 9 points is spaced 2^-18 apart. A fine set of 257 points is spaced 2^-15 apart. A coarse set of 257 points is spaced 2^-8 apart. Because the spacing is finest near black, very dark codes get much more precision than bright ones.

For each component the block chooses the finest set that covers the input and reads the two points on either side of it. It blends them linearly and then limits the result to a per-channel ceiling. The output has 3 integer bits and 16 fraction bits, so 1.0 is 65536.

Curve points are loaded through two index/data port pairs. One pair serves the superfine set. The other pair serves the fine and coarse sets together. A point is sent as two 32-bit words and carries a 16-bit value for each colour. A separate write port sets three ceiling values per channel. The first ceiling is used for inputs below 1.0. The second is used for inputs from 1.0 up to 3.0, and the third for inputs of 3.0 and above.

Top module: `multiseg_gamma`

## Requirements
- R1: After reset, `out_vld` and all three outputs are 0. Every ceiling register holds 65536, which is 1.0.
- R2: A pixel presented with `pix_vld` high appears on the outputs exactly 3 clock cycles later, with `out_vld` high for exactly one cycle. When no result is arriving, the outputs keep their previous values.
- R3: An input x below 8 (units of 2^-18) gives superfine point x exactly.
- R4: An input 8 <= x < 2048 blends fine point i = x>>3 and fine point i+1 with weight w = (x&7)*128. The result is p0 + floor((p1-p0)*w/1024).
- R5: An input 2048 <= x < 2^18 blends coarse point i = x>>10 and point i+1 with weight x&1023, using the same formula as R4. Coarse point 256 is the channel's base ceiling.
- R6: For inputs below 1.0, any blended result above the channel's base ceiling is output as the base ceiling.
- R7: An input with integer part 1 or 2 outputs the channel's first extended ceiling. An input with integer part 3 to 7 outputs the second extended ceiling. Neither value is limited by the base ceiling.
- R8: Each point is written as two words. The even word carries the low 6 bits of red, green and blue at bits 29:24, 19:14 and 5:0. The odd word carries the high 10 bits at bits 29:20, 19:10 and 9:0. The point is stored when the odd word is written.
- R9: A write to an index register loads the word pointer from bits [9:0] on the shared port, or bits [4:0] on the superfine port. Bit 15 of the same write sets auto-increment. With auto-increment on, each data write advances the pointer by one. With it off, the pointer stays where it is. Superfine word pointers 18 and above are ignored.
- R10: On the shared port, word pairs 0 to 255 store fine points 1 to 256. Word pairs 256 to 511 store coarse points 0 to 255.
- R11: A ceiling write takes `max_rng` 0 for base, 1 for first extended and 2 for second extended, and `max_ch` 0, 1 or 2 for red, green or blue. A write with `max_rng` 3 or `max_ch` 3 has no effect.
- R12: A pixel presented in the same cycle as the write that stores a point uses the old point. A pixel presented one cycle later uses the new point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Input pixel valid |
| pix_r | input | 21 | Red input, 3.18 unsigned |
| pix_g | input | 21 | Green input, 3.18 unsigned |
| pix_b | input | 21 | Blue input, 3.18 unsigned |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 19 | Red output, 3.16 unsigned |
| out_g | output | 19 | Green output, 3.16 unsigned |
| out_b | output | 19 | Blue output, 3.16 unsigned |
| sf_idx_wr | input | 1 | Superfine index register write strobe |
| sf_idx | input | 32 | Superfine index value: pointer in [4:0], auto-increment in bit 15 |
| sf_dat_wr | input | 1 | Superfine data write strobe |
| sf_dat | input | 32 | Superfine data word |
| sh_idx_wr | input | 1 | Shared fine/coarse index register write strobe |
| sh_idx | input | 32 | Shared index value: pointer in [9:0], auto-increment in bit 15 |
| sh_dat_wr | input | 1 | Shared data write strobe |
| sh_dat | input | 32 | Shared data word |
| max_wr | input | 1 | Ceiling register write strobe |
| max_rng | input | 2 | Ceiling select: 0 base, 1 first extended, 2 second extended |
| max_ch | input | 2 | Channel select: 0 red, 1 green, 2 blue |
| max_val | input | 19 | Ceiling value, 3.16 unsigned |

## Verification
A corrupted word pointer or a bad low-bit staging register shows up as wrong output values on the first pixel that reads the damaged point, 3 cycles after that pixel enters. This includes points loaded while auto-increment is off. A wrong segment choice or blend weight gives wrong values on boundary inputs such as 7, 8, 2047, 2048 and 2^18-1, again 3 cycles after they enter. A damaged ceiling register shows up only on clamped inputs and inputs of 1.0 and above, so those inputs are driven after every ceiling write. A mistake in the write-versus-read ordering is exposed by two back-to-back pixels around the storing write, whose results appear on consecutive cycles.

// File: rtl/mgam_pkg.sv
package mgam_pkg;
  localparam int IN_W     = 21;   // 3 integer + 18 fraction bits
  localparam int FRAC_W   = 18;
  localparam int OUT_W    = 19;   // 3 integer + 16 fraction bits
  localparam int PT_W     = 16;
  localparam int LO_W     = 6;
  localparam int HI_W     = PT_W - LO_W;
  localparam int W_W      = 10;   // blend weight, 1.0 = 2**W_W
  localparam int SF_PTS   = 9;
  localparam int FINE_PTS = 256;  // fine points 1..256 (point 0 not stored)
  localparam int CO_PTS   = 256;  // coarse points 0..255, point 256 = base ceiling
  localparam int AUTO_BIT = 15;
  localparam int NCH      = 3;
  localparam logic [OUT_W-1:0] ONE_OUT = OUT_W'(1 << 16);

  typedef struct packed {
    logic [PT_W-1:0] r;
    logic [PT_W-1:0] g;
    logic [PT_W-1:0] b;
  } rgb_pt_t;
endpackage

// File: rtl/mgam_wport.sv
module mgam_wport
  import mgam_pkg::*;
#(
  parameter int PTR_W  = 10,
  parameter int NWORDS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [31:0]      idx_val,
  input  logic             dat_wr,
  input  logic [31:0]      dat_val,
  output logic             commit,
  output logic [PTR_W-2:0] pt_addr,
  output rgb_pt_t          pt
);
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              auto_q, auto_d;
  logic [3*LO_W-1:0] lo_q, lo_d;
  logic              in_range;
  logic              unused_bits;

  assign unused_bits = ^{idx_val, dat_val[31:30]};

  always_comb begin
    ptr_d  = ptr_q;
    auto_d = auto_q;
    lo_d   = lo_q;
    if (dat_wr && !ptr_q[0])
      lo_d = {dat_val[29:24], dat_val[19:14], dat_val[5:0]};
    if (idx_wr) begin
      ptr_d  = idx_val[PTR_W-1:0];
      auto_d = idx_val[AUTO_BIT];
    end else if (dat_wr && auto_q) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      auto_q <= 1'b0;
      lo_q   <= '0;
    end else begin
      ptr_q  <= ptr_d;
      auto_q <= auto_d;
      lo_q   <= lo_d;
    end
  end

  assign in_range = (int'(ptr_q) < NWORDS);
  assign commit   = dat_wr && ptr_q[0] && in_range;
  assign pt_addr  = ptr_q[PTR_W-1:1];
  assign pt.r     = {dat_val[29:20], lo_q[3*LO_W-1:2*LO_W]};
  assign pt.g     = {dat_val[19:10], lo_q[2*LO_W-1:LO_W]};
  assign pt.b     = {dat_val[9:0],   lo_q[LO_W-1:0]};

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !(dat_wr && auto_q)) |=> $stable(ptr_q));
endmodule

// File: rtl/mgam_chan.sv
module mgam_chan
  import mgam_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en1,
  input  logic                en2,
  input  logic                en3,
  input  logic [IN_W-1:0]     x,
  input  logic                sf_we,
  input  logic [3:0]          sf_addr,
  input  logic [PT_W-1:0]     sf_pt,
  input  logic                sh_we,
  input  logic [8:0]          sh_addr,
  input  logic [PT_W-1:0]     sh_pt,
  input  logic [OUT_W-1:0]    gmax,
  input  logic [OUT_W-1:0]    emax1,
  input  logic [OUT_W-1:0]    emax2,
  output logic [OUT_W-1:0]    y
);
  localparam int INT_W  = IN_W - FRAC_W;
  localparam int SF_SH  = FRAC_W - 15;  // fine spacing 2^-15
  localparam int FI_TOP = FRAC_W - 7;   // fine range below 2^-7
  localparam int CO_SH  = FRAC_W - 8;   // coarse spacing 2^-8
  localparam int PROD_W = OUT_W + W_W + 2;

  logic [PT_W-1:0] sf_m   [SF_PTS];
  logic [PT_W-1:0] fine_m [FINE_PTS];
  logic [PT_W-1:0] co_m   [CO_PTS];

  always_ff @(posedge clk) begin
    if (sf_we) sf_m[sf_addr] <= sf_pt;
    if (sh_we) begin
      if (sh_addr[8]) co_m[sh_addr[7:0]]   <= sh_pt;
      else            fine_m[sh_addr[7:0]] <= sh_pt;
    end
  end

  // stage 1: segment pick and point read
  logic [OUT_W-1:0] p0_d, p1_d, lim_d, s1_p0, s1_p1, s1_lim;
  logic [W_W-1:0]   w_d, s1_w;
  logic [7:0]       fi, ci;
  logic [SF_SH-1:0] si;
  logic             over;

  assign over = |x[IN_W-1:FRAC_W];
  assign fi   = x[FI_TOP-1:SF_SH];
  assign ci   = x[FRAC_W-1:CO_SH];
  assign si   = x[SF_SH-1:0];

  always_comb begin
    p0_d  = '0;
    p1_d  = '0;
    w_d   = '0;
    lim_d = gmax;
    if (over) begin
      p0_d  = (x[IN_W-1:FRAC_W] >= INT_W'(3)) ? emax2 : emax1;
      p1_d  = p0_d;
      lim_d = '1;
    end else if (x[FRAC_W-1:SF_SH] == '0) begin
      p0_d = OUT_W'(sf_m[{1'b0, si}]);
      p1_d = p0_d;
    end else if (x[FRAC_W-1:FI_TOP] == '0) begin
      p0_d = OUT_W'(fine_m[fi - 8'd1]);
      p1_d = OUT_W'(fine_m[fi]);
      w_d  = {x[SF_SH-1:0], {(W_W-SF_SH){1'b0}}};
    end else begin
      p0_d = OUT_W'(co_m[ci]);
      p1_d = (ci == 8'hFF) ? gmax : OUT_W'(co_m[ci + 8'd1]);
      w_d  = x[CO_SH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_p0 <= '0; s1_p1 <= '0; s1_w <= '0; s1_lim <= '0;
    end else if (en1) begin
      s1_p0 <= p0_d; s1_p1 <= p1_d; s1_w <= w_d; s1_lim <= lim_d;
    end
  end

  // stage 2: linear blend
  logic signed [OUT_W:0]    diff;
  logic signed [PROD_W-1:0] prod;
  logic [OUT_W-1:0]         blend, s2_val, s2_lim;
  logic                     unused_prod;

  assign diff        = $signed({1'b0, s1_p1}) - $signed({1'b0, s1_p0});
  assign prod        = diff * $signed({1'b0, s1_w});
  assign blend       = s1_p0 + prod[OUT_W+W_W-1:W_W];
  assign unused_prod = ^{prod[PROD_W-1:OUT_W+W_W], prod[W_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_val <= '0; s2_lim <= '0;
    end else if (en2) begin
      s2_val <= blend; s2_lim <= s1_lim;
    end
  end

  // stage 3: ceiling
  logic [OUT_W-1:0] y_d, y_q;
  assign y_d = (s2_val > s2_lim) ? s2_lim : s2_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   y_q <= '0;
    else if (en3) y_q <= y_d;
  end
  assign y = y_q;

  // R4
  blend_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en2 |=> ((s2_val >= $past(s1_p0) || s2_val >= $past(s1_p1)) &&
             (s2_val <= $past(s1_p0) || s2_val <= $past(s1_p1))));
endmodule

// File: rtl/multiseg_gamma.sv
module multiseg_gamma
  import mgam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld,
  input  logic [IN_W-1:0]   pix_r,
  input  logic [IN_W-1:0]   pix_g,
  input  logic [IN_W-1:0]   pix_b,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_r,
  output logic [OUT_W-1:0]  out_g,
  output logic [OUT_W-1:0]  out_b,
  input  logic              sf_idx_wr,
  input  logic [31:0]       sf_idx,
  input  logic              sf_dat_wr,
  input  logic [31:0]       sf_dat,
  input  logic              sh_idx_wr,
  input  logic [31:0]       sh_idx,
  input  logic              sh_dat_wr,
  input  logic [31:0]       sh_dat,
  input  logic              max_wr,
  input  logic [1:0]        max_rng,
  input  logic [1:0]        max_ch,
  input  logic [OUT_W-1:0]  max_val
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // write ports
  logic       sf_cm, sh_cm;
  logic [3:0] sf_a;
  logic [8:0] sh_a;
  rgb_pt_t    sf_p, sh_p;

  mgam_wport #(.PTR_W(5), .NWORDS(2*SF_PTS)) u_sfport (
    .clk(clk), .rst_n(rst_i), .idx_wr(sf_idx_wr), .idx_val(sf_idx),
    .dat_wr(sf_dat_wr), .dat_val(sf_dat), .commit(sf_cm), .pt_addr(sf_a), .pt(sf_p));

  mgam_wport #(.PTR_W(10), .NWORDS(2*(FINE_PTS+CO_PTS))) u_shport (
    .clk(clk), .rst_n(rst_i), .idx_wr(sh_idx_wr), .idx_val(sh_idx),
    .dat_wr(sh_dat_wr), .dat_val(sh_dat), .commit(sh_cm), .pt_addr(sh_a), .pt(sh_p));

  // ceiling registers
  logic [OUT_W-1:0] gm_q [NCH], gm_d [NCH];
  logic [OUT_W-1:0] e1_q [NCH], e1_d [NCH];
  logic [OUT_W-1:0] e2_q [NCH], e2_d [NCH];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      gm_d[c] = gm_q[c];
      e1_d[c] = e1_q[c];
      e2_d[c] = e2_q[c];
      if (max_wr && (int'(max_ch) == c)) begin
        case (max_rng)
          2'd0:    gm_d[c] = max_val;
          2'd1:    e1_d[c] = max_val;
          2'd2:    e2_d[c] = max_val;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int c = 0; c < NCH; c++) begin
        gm_q[c] <= ONE_OUT; e1_q[c] <= ONE_OUT; e2_q[c] <= ONE_OUT;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        gm_q[c] <= gm_d[c]; e1_q[c] <= e1_d[c]; e2_q[c] <= e2_d[c];
      end
    end
  end

  // valid pipeline
  logic v1_q, v2_q, v3_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      v1_q <= 1'b0; v2_q <= 1'b0; v3_q <= 1'b0;
    end else begin
      v1_q <= pix_vld; v2_q <= v1_q; v3_q <= v2_q;
    end
  end
  assign out_vld = v3_q;

  // channels
  logic [IN_W-1:0]  x_in  [NCH];
  logic [OUT_W-1:0] y_out [NCH];
  logic [PT_W-1:0]  sf_c  [NCH];
  logic [PT_W-1:0]  sh_c  [NCH];

  assign x_in[0] = pix_r;  assign x_in[1] = pix_g;  assign x_in[2] = pix_b;
  assign sf_c[0] = sf_p.r; assign sf_c[1] = sf_p.g; assign sf_c[2] = sf_p.b;
  assign sh_c[0] = sh_p.r; assign sh_c[1] = sh_p.g; assign sh_c[2] = sh_p.b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    mgam_chan u_chan (
      .clk(clk), .rst_n(rst_i), .en1(pix_vld), .en2(v1_q), .en3(v2_q),
      .x(x_in[c]), .sf_we(sf_cm), .sf_addr(sf_a), .sf_pt(sf_c[c]),
      .sh_we(sh_cm), .sh_addr(sh_a), .sh_pt(sh_c[c]),
      .gmax(gm_q[c]), .emax1(e1_q[c]), .emax2(e2_q[c]), .y(y_out[c]));
  end

  assign out_r = y_out[0];
  assign out_g = y_out[1];
  assign out_b = y_out[2];

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_i)
    out_vld == $past(pix_vld, 3));
  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !v2_q |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
  // R11
  max_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !max_wr |=> ($stable(gm_q[0]) && $stable(e1_q[1]) && $stable(e2_q[2])));
endmodule

// File: tb/multiseg_gamma_test.sv
module multiseg_gamma_test;
  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, pix_vld, out_vld;
  logic [20:0] pix_r, pix_g, pix_b;
  logic [18:0] out_r, out_g, out_b;
  logic        sf_idx_wr, sf_dat_wr, sh_idx_wr, sh_dat_wr, max_wr;
  logic [31:0] sf_idx, sf_dat, sh_idx, sh_dat;
  logic [1:0]  max_rng, max_ch;
  logic [18:0] max_val;

  multiseg_gamma uut (.*);

  int nchk = 0, nerr = 0;
  bit done = 0;
  int sfm [3][9];
  int fim [3][257];
  int com [3][256];
  int gm [3], e1 [3], e2 [3];

  localparam int NV = 8;
  localparam int VX [NV][3] = '{
    '{0, 7, 3}, '{8, 15, 2047}, '{9, 100, 1000}, '{2048, 2049, 3071},
    '{100000, 150000, 262143}, '{262143, 261120, 262000},
    '{262144, 786431, 786432}, '{2097151, 5, 130000}};

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic w_sfi(int v); sf_idx = v; sf_idx_wr = 1; tick; sf_idx_wr = 0; endtask
  task automatic w_sfd(int v); sf_dat = v; sf_dat_wr = 1; tick; sf_dat_wr = 0; endtask
  task automatic w_shi(int v); sh_idx = v; sh_idx_wr = 1; tick; sh_idx_wr = 0; endtask
  task automatic w_shd(int v); sh_dat = v; sh_dat_wr = 1; tick; sh_dat_wr = 0; endtask
  task automatic w_max(int rng, int ch, int v);
    max_rng = rng[1:0]; max_ch = ch[1:0]; max_val = v[18:0]; max_wr = 1; tick; max_wr = 0;
  endtask

  function automatic int lo_word(int r, int g, int b);
    return ((r & 63) << 24) | ((g & 63) << 14) | (b & 63);
  endfunction
  function automatic int hi_word(int r, int g, int b);
    return ((r >> 6) << 20) | ((g >> 6) << 10) | (b >> 6);
  endfunction

  task automatic put_pt(bit shared, int r, int g, int b);
    if (shared) begin w_shd(lo_word(r, g, b)); w_shd(hi_word(r, g, b)); end
    else        begin w_sfd(lo_word(r, g, b)); w_sfd(hi_word(r, g, b)); end
  endtask

  function automatic int ref_out(int c, int x);
    int v, p0, p1, w, i;
    if (x >= 262144) return ((x >> 18) >= 3) ? e2[c] : e1[c];
    if (x < 8) v = sfm[c][x];
    else begin
      if (x < 2048) begin
        i = x >> 3; p0 = fim[c][i]; p1 = fim[c][i+1]; w = (x & 7) * 128;
      end else begin
        i = x >> 10; p0 = com[c][i]; p1 = (i == 255) ? gm[c] : com[c][i+1]; w = x & 1023;
      end
      v = p0 + (((p1 - p0) * w) >>> 10);
    end
    if (v > gm[c]) v = gm[c];
    return v;
  endfunction

  function automatic string seg_tag(int x);
    if (x >= 262144) return "R7";
    if (x < 8) return "R3";
    if (x < 2048) return "R4";
    return "R5";
  endfunction

  task automatic run_px(int xr, int xg, int xb, string tag);
    int er, eg, eb;
    er = ref_out(0, xr); eg = ref_out(1, xg); eb = ref_out(2, xb);
    pix_r = xr[20:0]; pix_g = xg[20:0]; pix_b = xb[20:0]; pix_vld = 1;
    tick; pix_vld = 0; tick; tick;
    chk({tag, " valid"}, int'(out_vld), 1);
    chk({tag, " red"}, int'(out_r), er);
    chk({tag, " green"}, int'(out_g), eg);
    chk({tag, " blue"}, int'(out_b), eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int old_r, new_r, nv;
    rst_n = 0; pix_vld = 0; pix_r = 0; pix_g = 0; pix_b = 0;
    sf_idx_wr = 0; sf_dat_wr = 0; sh_idx_wr = 0; sh_dat_wr = 0; max_wr = 0;
    sf_idx = 0; sf_dat = 0; sh_idx = 0; sh_dat = 0; max_rng = 0; max_ch = 0; max_val = 0;
    for (int c = 0; c < 3; c++) begin
      gm[c] = 65536; e1[c] = 65536; e2[c] = 65536;
      for (int k = 0; k < 9; k++)   sfm[c][k] = 100 + k * 3 + c * 10;
      for (int p = 1; p < 257; p++) fim[c][p] = 1000 + p * 40 + c * 5;
      for (int p = 0; p < 256; p++) com[c][p] = 12000 + p * 200 + c * 3;
    end
    repeat (3) tick;
    // R1 reset state at the ports
    chk("R1 out_vld", int'(out_vld), 0);
    chk("R1 out_r", int'(out_r), 0);
    chk("R1 out_b", int'(out_b), 0);
    rst_n = 1;
    repeat (4) tick;

    // load all points with auto-increment (R8, R9, R10)
    w_sfi(32'h8000);
    for (int k = 0; k < 9; k++) put_pt(0, sfm[0][k], sfm[1][k], sfm[2][k]);
    w_shi(32'h8000);
    for (int p = 1; p < 257; p++) put_pt(1, fim[0][p], fim[1][p], fim[2][p]);
    for (int p = 0; p < 256; p++) put_pt(1, com[0][p], com[1][p], com[2][p]);

    // R1 default ceilings seen through over-range and top coarse inputs
    run_px(262144, 1048576, 262143, "R1");

    // table walk across segments (R3 R4 R5 R7)
    for (int i = 0; i < NV; i++) begin
      run_px(VX[i][0], VX[i][1], VX[i][2],
             {seg_tag(VX[i][0]), "/", seg_tag(VX[i][1]), "/", seg_tag(VX[i][2])});
    end

    // R2 latency and single-cycle valid
    pix_r = 21'd50; pix_g = 21'd50; pix_b = 21'd50; pix_vld = 1;
    tick; pix_vld = 0; tick;
    chk("R2 valid early", int'(out_vld), 0);
    tick;
    chk("R2 valid on time", int'(out_vld), 1);
    tick;
    chk("R2 valid drops", int'(out_vld), 0);
    chk("R2 output held", int'(out_r), ref_out(0, 50));

    // R9 pointer holds without auto-increment; R8 staging of low bits
    w_sfi(4);
    w_sfd(lo_word(16'h1111, 16'h2222, 16'h3333));
    w_sfd(lo_word(16'hABCD, 16'h1234, 16'hFFC1));
    w_sfi(5);
    w_sfd(hi_word(16'hABCD, 16'h1234, 16'hFFC1));
    sfm[0][2] = 16'hABCD; sfm[1][2] = 16'h1234; sfm[2][2] = 16'hFFC1;
    run_px(2, 2, 2, "R9 R8");
    // superfine words beyond 17 do nothing to points in use (R9)
    w_sfi(32'h8000 | 18);
    put_pt(0, 9, 9, 9);
    run_px(2, 1, 0, "R9 high words");

    // R10 shared mapping around the fine/coarse seam
    w_shi(32'h8000 | 510);
    put_pt(1, 7000, 7100, 7200);
    put_pt(1, 400, 500, 600);
    fim[0][256] = 7000; fim[1][256] = 7100; fim[2][256] = 7200;
    com[0][0] = 400; com[1][0] = 500; com[2][0] = 600;
    run_px(2047, 2048, 2047, "R10");
    run_px(2048, 2047, 3000, "R10");

    // R11 ceiling writes, invalid selects ignored; R6 clamp; R7
    w_max(1, 0, 70000);  e1[0] = 70000;
    w_max(2, 1, 123456); e2[1] = 123456;
    w_max(0, 2, 30000);  gm[2] = 30000;
    w_max(3, 0, 1);
    w_max(0, 3, 1);
    run_px(262144, 786432, 262143, "R11 R6");
    run_px(1048576, 262144, 100000, "R11 R7");
    run_px(262143, 300000, 2048, "R11 R6");

    // R12 write landing with a pixel: first pixel old, next pixel new
    old_r = ref_out(0, 100);
    w_shi(32'h8000 | 22);
    nv = 5000;
    sh_dat = lo_word(nv, nv, nv); sh_dat_wr = 1; tick;
    sh_dat = hi_word(nv, nv, nv);
    pix_r = 21'd100; pix_g = 21'd100; pix_b = 21'd100; pix_vld = 1;
    tick;
    sh_dat_wr = 0;
    for (int c = 0; c < 3; c++) fim[c][12] = nv;
    new_r = ref_out(0, 100);
    tick; pix_vld = 0; tick;
    chk("R12 old point", int'(out_r), old_r);
    tick;
    chk("R12 new point", int'(out_r), new_r);
    chk("R12 new point blue", int'(out_b), ref_out(2, 100));

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule